// File: doc/BRIEF.md
# Floppy Orders Latch and Stepper

This block takes the controller's order byte, which arrives as a one-cycle write strobe carrying an 8-bit value, and keeps it in a register. From that register it drives the recording density, the head side, the step direction and the step level. It also drives a one-hot select for up to four drives. For every drive it holds a head position in tracks. That position is the block's model of where each drive's head sits.

A step is not triggered by the step level alone. It happens only when an order carries step level 0 and the order before it carried step level 1. That falling edge moves the head of the drive named in the new order by one track. The new position is held between track 0 and the last track. After each order the block reports the selected drive's track and a track-zero flag for that drive.

Top module: `floppy_order_stepper`

## Requirements
- R1: While reset is asserted, and after it is released, every output is 0. All track positions and the saved step level are cleared to 0, so selecting any drive after reset shows track 0 with the zero flag set.
- R2: On a clock edge with `ord_wr` high, the order register takes `ord_val`. Bit 7 then appears on `dens_o`, bit 6 on `side_o`, bit 5 on `dir_o` and bit 4 on `step_o` after that edge. With `ord_wr` low these outputs hold their values.
- R3: Bits 3..0 of the order form the drive code. Code 1, 2, 4 or 8 sets `sel_o` bit 0, 1, 2 or 3 respectively. Code 0 and every code that is not one-hot leave `sel_o` at 0.
- R4: A head moves only when the new order's bit 4 is 0 and the previous order's bit 4 was 1. Orders that keep bit 4 at 1, keep it at 0, or raise it from 0 to 1 move nothing.
- R5: On a step, bit 5 = 1 moves the head one track inward (track + 1) and bit 5 = 0 moves it one track outward (track − 1).
- R6: Track positions stay within 0..34 (NUM_TRACKS = 35). A step outward at track 0 or inward at track 34 leaves the track unchanged.
- R7: Each drive keeps its own track. A step applies only to the drive named in the same order that carries the falling step level.
- R8: After every order, `sel_track_o` shows the selected drive's track and `trk_zero_o` is 1 exactly when that track is 0. With no drive selected, both are 0.
- R9: Every order saves its step level, even when it selects no drive. A falling step level in an order that selects no drive moves no head, yet it still sets the saved level to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ord_wr | input | 1 | Single-cycle strobe that writes an order |
| ord_val | input | 8 | Order byte written with the strobe |
| dens_o | output | 1 | Density level, 1 = double |
| side_o | output | 1 | Side select, 1 = second side |
| dir_o | output | 1 | Step direction / precompensation level |
| step_o | output | 1 | Step level held from the last order |
| sel_o | output | 4 | One-hot drive select, all zero = none |
| sel_track_o | output | 6 | Track of the selected drive |
| trk_zero_o | output | 1 | Selected drive is at track 0 |

## Verification
Two things can happen in the same order: the step level falls, and the drive select changes to another drive. The bench provokes this on purpose. It raises the step level on one drive, or with no drive selected, and then issues an order that names a different drive with step level 0. The step must move only the newly named drive. In that same cycle, the zero flag and the reported track must be recomputed from that drive's updated position. A behavioural model that holds per-drive integers and the last step level judges every clock, and directed checks confirm the exact track values at the clamps.

// File: rtl/fos_pkg.sv
`timescale 1ns/1ps
package fos_pkg;

   // Field layout of an order byte; positions are decoded by the stepper.
   typedef struct packed {
      logic       dens;   // bit 7
      logic       side;   // bit 6
      logic       dir;    // bit 5
      logic       step;   // bit 4
      logic [3:0] code;   // bits 3..0
   } order_t;

   localparam int ORDER_BITS = $bits(order_t);
   localparam int CODE_BITS  = 4;

endpackage

// File: rtl/fos_select_dec.sv
`timescale 1ns/1ps
module fos_select_dec #(
   parameter int NUM_DRIVES = 4,
   parameter int CODE_W     = 4
) (
   input  logic [CODE_W-1:0]     code,
   output logic [NUM_DRIVES-1:0] sel
);

   generate
      if (NUM_DRIVES > CODE_W) begin : g_bad_cfg
         $error("fos_select_dec: more drives than code bits");
      end
   endgenerate

   // Exact one-hot match per drive; zero or multi-bit codes hit nothing.
   genvar gi;
   generate
      for (gi = 0; gi < NUM_DRIVES; gi++) begin : g_hit
         assign sel[gi] = (code == CODE_W'(1 << gi));
      end
   endgenerate

endmodule

// File: rtl/fos_track_unit.sv
`timescale 1ns/1ps
module fos_track_unit #(
   parameter int NUM_TRACKS = 35,
   parameter int TRK_W      = $clog2(NUM_TRACKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             move,
   input  logic             inward,
   output logic [TRK_W-1:0] track_o
);

   localparam logic [TRK_W-1:0] LAST = TRK_W'(NUM_TRACKS - 1);

   generate
      if (NUM_TRACKS < 2) begin : g_bad_cfg
         $error("fos_track_unit: need at least two tracks");
      end
   endgenerate

   logic [TRK_W-1:0] trk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trk_q <= '0;
      end else if (move) begin
         if (inward) begin
            if (trk_q != LAST) trk_q <= trk_q + TRK_W'(1);
         end else begin
            if (trk_q != '0) trk_q <= trk_q - TRK_W'(1);
         end
      end
   end

   assign track_o = trk_q;

   // R6: position never leaves the legal range
   p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trk_q <= LAST);

   // R4: without a step request the head stays put
   p_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !move |=> $stable(trk_q));

   // R5: inward step adds one track below the top
   p_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (move && inward && trk_q != LAST) |=> trk_q == $past(trk_q) + TRK_W'(1));

   // R5: outward step removes one track above zero
   p_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (move && !inward && trk_q != '0) |=> trk_q == $past(trk_q) - TRK_W'(1));

endmodule

// File: rtl/fos_status_mux.sv
`timescale 1ns/1ps
module fos_status_mux #(
   parameter int NUM_DRIVES = 4,
   parameter int TRK_W      = 6
) (
   input  logic [NUM_DRIVES-1:0]       sel,
   input  logic [NUM_DRIVES*TRK_W-1:0] tracks,
   output logic [TRK_W-1:0]            sel_track,
   output logic                        at_zero
);

   logic [TRK_W-1:0] acc;

   // AND-OR mux: select is one-hot or empty, so empty yields zero.
   always_comb begin
      acc = '0;
      for (int i = 0; i < NUM_DRIVES; i++) begin
         acc = acc | (tracks[i*TRK_W +: TRK_W] & {TRK_W{sel[i]}});
      end
   end

   assign sel_track = acc;
   assign at_zero   = (|sel) && (acc == '0);

endmodule

// File: rtl/floppy_order_stepper.sv
`timescale 1ns/1ps
module floppy_order_stepper #(
   parameter int NUM_DRIVES = 4,
   parameter int NUM_TRACKS = 35,
   parameter int TRK_W      = $clog2(NUM_TRACKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ord_wr,
   input  logic [7:0]            ord_val,
   output logic                  dens_o,
   output logic                  side_o,
   output logic                  dir_o,
   output logic                  step_o,
   output logic [NUM_DRIVES-1:0] sel_o,
   output logic [TRK_W-1:0]      sel_track_o,
   output logic                  trk_zero_o
);
   import fos_pkg::*;

   generate
      if (ORDER_BITS != 8) begin : g_bad_order
         $error("floppy_order_stepper: order must be 8 bits");
      end
      if ((1 << TRK_W) < NUM_TRACKS) begin : g_bad_trk
         $error("floppy_order_stepper: TRK_W too narrow");
      end
   endgenerate

   order_t                  ord_q;
   order_t                  ord_new;
   logic [NUM_DRIVES-1:0]   sel_q;
   logic [NUM_DRIVES-1:0]   sel_new;
   logic                    fall;
   logic [NUM_DRIVES*TRK_W-1:0] trk_flat;

   assign ord_new = order_t'(ord_val);

   // Decode the incoming code so the step hits the drive named now.
   fos_select_dec #(.NUM_DRIVES(NUM_DRIVES), .CODE_W(CODE_BITS)) u_dec (
      .code (ord_new.code),
      .sel  (sel_new)
   );

   // The held step bit is the previous level; a write replaces it always.
   assign fall = ord_wr && ord_q.step && !ord_new.step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ord_q <= '0;
         sel_q <= '0;
      end else if (ord_wr) begin
         ord_q <= ord_new;
         sel_q <= sel_new;
      end
   end

   genvar gd;
   generate
      for (gd = 0; gd < NUM_DRIVES; gd++) begin : g_drv
         fos_track_unit #(.NUM_TRACKS(NUM_TRACKS), .TRK_W(TRK_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .move    (fall && sel_new[gd]),
            .inward  (ord_new.dir),
            .track_o (trk_flat[gd*TRK_W +: TRK_W])
         );
      end
   endgenerate

   fos_status_mux #(.NUM_DRIVES(NUM_DRIVES), .TRK_W(TRK_W)) u_stat (
      .sel       (sel_q),
      .tracks    (trk_flat),
      .sel_track (sel_track_o),
      .at_zero   (trk_zero_o)
   );

   assign dens_o = ord_q.dens;
   assign side_o = ord_q.side;
   assign dir_o  = ord_q.dir;
   assign step_o = ord_q.step;
   assign sel_o  = sel_q;

   // R2: level outputs follow the written byte one edge later
   p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ord_wr |=> (dens_o == $past(ord_val[7]) && step_o == $past(ord_val[4])));

   // R2: no write, no change
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ord_wr |=> ($stable(sel_o) && $stable(dir_o) && $stable(side_o)));

   // R3: never more than one drive selected
   p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));

   // R8: with no drive, status reads as zero
   p_nodrv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o == '0) |-> (!trk_zero_o && sel_track_o == '0));

endmodule

// File: tb/sim_floppy_order_stepper.sv
`timescale 1ns/1ps
module sim_floppy_order_stepper;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ord_wr = 1'b0;
   logic [7:0] ord_val = 8'h00;
   logic       dens_o, side_o, dir_o, step_o, trk_zero_o;
   logic [3:0] sel_o;
   logic [5:0] sel_track_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit cmp_on = 0;

   always #2.5 clk = ~clk;

   floppy_order_stepper u0 (
      .clk(clk), .rst_n(rst_n), .ord_wr(ord_wr), .ord_val(ord_val),
      .dens_o(dens_o), .side_o(side_o), .dir_o(dir_o), .step_o(step_o),
      .sel_o(sel_o), .sel_track_o(sel_track_o), .trk_zero_o(trk_zero_o)
   );

   // ---------------- behavioural reference ----------------
   int         m_trk [4];
   bit         m_prev;
   logic [7:0] m_ord;

   function automatic int drive_of(input logic [3:0] c);
      case (c)
         4'd1: return 0;
         4'd2: return 1;
         4'd4: return 2;
         4'd8: return 3;
         default: return -1;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_trk[i]) m_trk[i] = 0;
         m_prev = 0;
         m_ord  = 8'h00;
      end else if (ord_wr) begin
         int d;
         d = drive_of(ord_val[3:0]);
         if (m_prev && !ord_val[4] && d >= 0) begin
            if (ord_val[5]) begin
               if (m_trk[d] < 34) m_trk[d] = m_trk[d] + 1;
            end else begin
               if (m_trk[d] > 0) m_trk[d] = m_trk[d] - 1;
            end
         end
         m_prev = ord_val[4];
         m_ord  = ord_val;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every clock, away from the active edge.
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         int d;
         d = drive_of(m_ord[3:0]);
         chk("R2 dens", dens_o, m_ord[7]);
         chk("R2 side", side_o, m_ord[6]);
         chk("R2 dir",  dir_o,  m_ord[5]);
         chk("R2 step", step_o, m_ord[4]);
         chk("R3 sel",  sel_o,  (d >= 0) ? (1 << d) : 0);
         chk("R8 track", sel_track_o, (d >= 0) ? m_trk[d] : 0);
         chk("R8 zero",  trk_zero_o, (d >= 0 && m_trk[d] == 0) ? 1 : 0);
      end
   end

   task automatic wr(input logic [7:0] b);
      @(negedge clk);
      ord_wr  = 1'b1;
      ord_val = b;
      @(negedge clk);
      ord_wr  = 1'b0;
   endtask

   task automatic step_pair(input logic [7:0] hi, input logic [7:0] lo);
      wr(hi);
      wr(lo);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #500000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1 sel in reset", sel_o, 0);
      chk("R1 zero in reset", trk_zero_o, 0);
      chk("R1 levels in reset", {dens_o, side_o, dir_o, step_o}, 0);
      rst_n = 1'b1;
      cmp_on = 1;
      @(negedge clk);
      chk("R1 track after reset", sel_track_o, 0);

      wr(8'h01);
      chk("R1 drive1 at zero", trk_zero_o, 1);

      // R5 inward
      step_pair(8'h31, 8'h21);
      chk("R5 inward to 1", sel_track_o, 1);
      // R4 level held high: no step
      wr(8'h31); wr(8'h31);
      chk("R4 high held", sel_track_o, 1);
      wr(8'h21);
      chk("R4 fall steps", sel_track_o, 2);
      wr(8'h21);
      chk("R4 low held", sel_track_o, 2);
      // R5 outward
      step_pair(8'h11, 8'h01);
      chk("R5 outward to 1", sel_track_o, 1);

      // R6 low clamp on drive 2
      step_pair(8'h12, 8'h02);
      chk("R6 low clamp", sel_track_o, 0);
      chk("R6 low clamp zero", trk_zero_o, 1);
      // R6 high clamp on drive 3
      for (int k = 0; k < 40; k++) step_pair(8'h34, 8'h24);
      chk("R6 high clamp", sel_track_o, 34);

      // R7 independence
      wr(8'h01);
      chk("R7 drive1 kept", sel_track_o, 1);
      wr(8'h08);
      chk("R7 drive4 untouched", sel_track_o, 0);
      // R7 step lands on drive named with the falling level
      wr(8'h31);
      wr(8'h28);
      chk("R7 step on new drive", sel_track_o, 1);
      wr(8'h01);
      chk("R7 old drive unchanged", sel_track_o, 1);

      // R9 level saved with no drive selected
      wr(8'h30);
      chk("R3 code0 none", sel_o, 0);
      wr(8'h21);
      chk("R9 prev from no-drive order", sel_track_o, 2);
      wr(8'h31);
      wr(8'h20);
      chk("R9 no-drive fall moves none", sel_track_o, 0);
      wr(8'h21);
      chk("R9 level consumed", sel_track_o, 2);
      wr(8'h33);
      chk("R3 non-onehot none", sel_o, 0);
      wr(8'h06);
      chk("R3 multi-bit none", sel_o, 0);
      wr(8'hC4);
      chk("R2 density/side", {dens_o, side_o}, 3);
      chk("R3 code4 drive3", sel_o, 4);

      // R2/R3/R8 random orders, idle gaps included
      for (int k = 0; k < 400; k++) begin
         wr(8'($urandom));
         if (($urandom % 4) == 0) repeat (2) @(negedge clk);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule